// File: doc/BRIEF.md
# System Memory Address Router

This block sorts memory requests in the extended space, from 1 MB up to the top of the 32-bit space, into one of four targets. The targets are main DRAM, the downstream PCI hub port, the graphics control register window, and a DRAM-backed graphics frame buffer. The frame buffer target is reported separately so that its traffic can be counted apart from ordinary memory.

Several settings move the regions around. The top of main memory marks where DRAM ends and PCI begins. A protected SMRAM window of 512 KB or 1 MB sits just under that top. DRAM in that window is given only to requesters in SMM; every other access there goes to PCI. The frame buffer, also 512 KB or 1 MB, sits directly beneath the SMRAM window when the window is on, and directly beneath the top of memory when it is off. An optional legacy hole at 15 MB to 16 MB sends its accesses to PCI without remapping the DRAM behind it. A 512 KB register window can be placed at any 512 KB-aligned base.

Requests below 1 MB are left to an external legacy decoder. For these the block returns a valid response with no target bit set. The block also raises a configuration error when the register window or the frame buffer touches the interrupt-controller range or the boot-firmware range near the top of the space.

Top module: `sys_addr_router`

## Requirements
- R1: A valid request with an address below 0x0010_0000 gives a response with rsp_target equal to 4'b0000.
- R2: rsp_target is one-hot with bit 0 = DRAM, bit 1 = PCI, bit 2 = graphics registers and bit 3 = graphics buffer. An address from 1 MB up to, but not including, the top of memory (cfg_tom, in 512 KB blocks) selects DRAM unless a higher-priority region claims it.
- R3: An address at or above the top of memory selects PCI unless the register window claims it.
- R4: With cfg_isa_hole_en set, addresses 0x00F0_0000 to 0x00FF_FFFF select PCI. With it clear, the same addresses follow the normal DRAM and PCI rules.
- R5: With cfg_smr_en set, the SMRAM window covers the last 1 block (cfg_smr_1m=0) or the last 2 blocks (cfg_smr_1m=1) below the top of memory. It selects DRAM when req_smm=1 and PCI when req_smm=0.
- R6: With cfg_gbuf_en set, the graphics buffer covers 1 block (cfg_gbuf_1m=0) or 2 blocks (cfg_gbuf_1m=1). It ends at the SMRAM window's lower edge when SMRAM is enabled, and at the top of memory otherwise. It selects bit 3.
- R7: The 512 KB block whose index equals cfg_greg_base selects bit 2. This takes priority over SMRAM, the graphics buffer, the legacy hole, DRAM and PCI.
- R8: rsp_valid follows req_valid by exactly one clock. The target is decoded from the address and configuration present at that request's clock edge. rsp_target is 4'b0000 while rsp_valid is low.
- R9: cfg_err goes high one clock after the configuration has either of two faults. One fault is the register window lying in blocks 0x1FD8–0x1FD9 (interrupt controller) or 0x1FFC–0x1FFF (boot firmware). The other is an enabled graphics buffer overlapping either of those ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_smm | input | 1 | Requester is in SMM |
| cfg_tom | input | 14 | Top of main memory in 512 KB blocks |
| cfg_isa_hole_en | input | 1 | Enable 15–16 MB hole |
| cfg_smr_en | input | 1 | Enable SMRAM window |
| cfg_smr_1m | input | 1 | SMRAM window size: 0 = 512 KB, 1 = 1 MB |
| cfg_gbuf_en | input | 1 | Enable graphics buffer |
| cfg_gbuf_1m | input | 1 | Graphics buffer size: 0 = 512 KB, 1 = 1 MB |
| cfg_greg_base | input | 13 | Register window block index |
| rsp_valid | output | 1 | Registered response strobe |
| rsp_target | output | 4 | One-hot target select |
| cfg_err | output | 1 | Registered configuration overlap flag |

## Verification
A wrong bound in the window bank is visible at the ports. It shows up on the first response whose address falls one block on either side of a region edge. Such a bound sends the access to a neighbouring target, and the bench aims a large share of its addresses at those edges. A broken priority stage shows on the next response that hits two overlapping windows. Depending on the fault, that response carries two target bits or the lower-priority target. Faults in the overlap checker appear on cfg_err in the clock that follows the configuration change.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;
   localparam int TGT_N    = 4;
   localparam int TGT_DRAM = 0;
   localparam int TGT_PCI  = 1;
   localparam int TGT_GREG = 2;
   localparam int TGT_GMEM = 3;
   typedef logic [TGT_N-1:0] tgt_t;

   // decode windows, lowest index wins
   localparam int WIN_GREG = 0;
   localparam int WIN_SMR  = 1;
   localparam int WIN_GBUF = 2;
   localparam int WIN_ISA  = 3;
   localparam int WIN_DRAM = 4;
   localparam int WIN_HIGH = 5;
   localparam int WIN_N    = 6;
endpackage

// File: rtl/arr_window_bank.sv
module arr_window_bank #(
   parameter int N = 6,
   parameter int W = 14
) (
   input  logic [W-1:0]        blk,
   input  logic [N-1:0]        en,
   input  logic [N-1:0][W-1:0] lo,
   input  logic [N-1:0][W-1:0] hi,
   output logic [N-1:0]        hit
);
   for (genvar i = 0; i < N; i++) begin : g_win
      logic ge_lo, lt_hi;
      assign ge_lo  = (blk >= lo[i]);
      assign lt_hi  = (blk <  hi[i]);
      assign hit[i] = en[i] & ge_lo & lt_hi;
   end
endmodule

// File: rtl/arr_first_hit.sv
module arr_first_hit #(
   parameter int N = 6
) (
   input  logic [N-1:0] hit,
   output logic [N-1:0] first
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_pri
      assign first[i]  = hit[i] & ~seen[i];
      assign seen[i+1] = seen[i] | hit[i];
   end
endmodule

// File: rtl/arr_cfg_check.sv
module arr_cfg_check #(
   parameter int W           = 14,
   parameter int APIC_LO_BLK = 'h1FD8,
   parameter int APIC_HI_BLK = 'h1FDA,
   parameter int BIOS_LO_BLK = 'h1FFC,
   parameter int BIOS_HI_BLK = 'h2000
) (
   input  logic [W-1:0] greg_blk,
   input  logic         gbuf_en,
   input  logic [W-1:0] gbuf_lo,
   input  logic [W-1:0] gbuf_hi,
   output logic         bad
);
   localparam int NRES = 2;
   localparam logic [NRES-1:0][W-1:0] RES_LO = {W'(BIOS_LO_BLK), W'(APIC_LO_BLK)};
   localparam logic [NRES-1:0][W-1:0] RES_HI = {W'(BIOS_HI_BLK), W'(APIC_HI_BLK)};

   logic [NRES-1:0] greg_in, gbuf_ovl;
   for (genvar r = 0; r < NRES; r++) begin : g_res
      assign greg_in[r]  = (greg_blk >= RES_LO[r]) && (greg_blk < RES_HI[r]);
      assign gbuf_ovl[r] = gbuf_en && (gbuf_lo < RES_HI[r]) && (RES_LO[r] < gbuf_hi);
   end
   assign bad = (|greg_in) | (|gbuf_ovl);
endmodule

// File: rtl/sys_addr_router.sv
module sys_addr_router
   import addr_route_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLK_LG      = 19,
   parameter int APIC_LO_BLK = 'h1FD8,
   parameter int APIC_HI_BLK = 'h1FDA,
   parameter int BIOS_LO_BLK = 'h1FFC,
   parameter int BIOS_HI_BLK = 'h2000,
   localparam int BLK_W      = ADDR_W - BLK_LG,
   localparam int BW         = BLK_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_smm,
   input  logic [BLK_W:0]    cfg_tom,
   input  logic              cfg_isa_hole_en,
   input  logic              cfg_smr_en,
   input  logic              cfg_smr_1m,
   input  logic              cfg_gbuf_en,
   input  logic              cfg_gbuf_1m,
   input  logic [BLK_W-1:0]  cfg_greg_base,
   output logic              rsp_valid,
   output logic [TGT_N-1:0]  rsp_target,
   output logic              cfg_err
);
   localparam int LOW_BLK    = (1 << 20) >> BLK_LG;
   localparam int ISA_LO_BLK = (15 << 20) >> BLK_LG;
   localparam int ISA_HI_BLK = (16 << 20) >> BLK_LG;
   localparam int SPACE_BLK  = 1 << BLK_W;

   initial begin
      assert (BLK_LG == 19) else $error("window granule must be 512 KB");
      assert (ADDR_W > 24 && ADDR_W <= 32) else $error("address width out of range");
      assert (APIC_LO_BLK < APIC_HI_BLK && BIOS_LO_BLK < BIOS_HI_BLK)
         else $error("reserved ranges malformed");
   end

   // block index of the request
   logic [BW-1:0] req_blk;
   assign req_blk = {1'b0, req_addr[ADDR_W-1:BLK_LG]};

   // carve-out bounds
   logic [BW-1:0] smr_sz, gbuf_sz, smr_lo, gbuf_hi, gbuf_lo, greg_lo, greg_hi;
   always_comb begin
      smr_sz  = cfg_smr_1m  ? BW'(2) : BW'(1);
      gbuf_sz = cfg_gbuf_1m ? BW'(2) : BW'(1);
      smr_lo  = cfg_tom - smr_sz;
      gbuf_hi = cfg_smr_en ? smr_lo : cfg_tom;
      gbuf_lo = gbuf_hi - gbuf_sz;
      greg_lo = {1'b0, cfg_greg_base};
      greg_hi = greg_lo + BW'(1);
   end

   // window table
   logic [WIN_N-1:0]         win_en;
   logic [WIN_N-1:0][BW-1:0] win_lo, win_hi;
   always_comb begin
      win_en           = '1;
      win_en[WIN_SMR]  = cfg_smr_en;
      win_en[WIN_GBUF] = cfg_gbuf_en;
      win_en[WIN_ISA]  = cfg_isa_hole_en;
      win_lo[WIN_GREG] = greg_lo;            win_hi[WIN_GREG] = greg_hi;
      win_lo[WIN_SMR]  = smr_lo;             win_hi[WIN_SMR]  = cfg_tom;
      win_lo[WIN_GBUF] = gbuf_lo;            win_hi[WIN_GBUF] = gbuf_hi;
      win_lo[WIN_ISA]  = BW'(ISA_LO_BLK);    win_hi[WIN_ISA]  = BW'(ISA_HI_BLK);
      win_lo[WIN_DRAM] = BW'(LOW_BLK);       win_hi[WIN_DRAM] = cfg_tom;
      win_lo[WIN_HIGH] = BW'(LOW_BLK);       win_hi[WIN_HIGH] = BW'(SPACE_BLK);
   end

   logic [WIN_N-1:0] hit, first;
   logic             above_low;
   assign above_low = (req_blk >= BW'(LOW_BLK));

   arr_window_bank #(.N(WIN_N), .W(BW)) u_bank (
      .blk (req_blk),
      .en  (win_en & {WIN_N{above_low}}),
      .lo  (win_lo),
      .hi  (win_hi),
      .hit (hit)
   );

   arr_first_hit #(.N(WIN_N)) u_pri (
      .hit   (hit),
      .first (first)
   );

   // window to target mapping
   tgt_t tgt_d;
   always_comb begin
      tgt_d = '0;
      tgt_d[TGT_GREG] = first[WIN_GREG];
      tgt_d[TGT_GMEM] = first[WIN_GBUF];
      tgt_d[TGT_DRAM] = first[WIN_DRAM] | (first[WIN_SMR] & req_smm);
      tgt_d[TGT_PCI]  = first[WIN_HIGH] | first[WIN_ISA] | (first[WIN_SMR] & ~req_smm);
   end

   logic err_d;
   arr_cfg_check #(
      .W(BW), .APIC_LO_BLK(APIC_LO_BLK), .APIC_HI_BLK(APIC_HI_BLK),
      .BIOS_LO_BLK(BIOS_LO_BLK), .BIOS_HI_BLK(BIOS_HI_BLK)
   ) u_chk_cfg (
      .greg_blk (greg_lo),
      .gbuf_en  (cfg_gbuf_en),
      .gbuf_lo  (gbuf_lo),
      .gbuf_hi  (gbuf_hi),
      .bad      (err_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_target <= '0;
         cfg_err    <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_target <= req_valid ? tgt_d : '0;
         cfg_err    <= err_d;
      end
   end
endmodule

// File: rtl/sys_addr_router_chk.sv
module sys_addr_router_chk #(
   parameter int ADDR_W = 32,
   parameter int BLK_LG = 19,
   localparam int BLK_W = ADDR_W - BLK_LG
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              req_smm,
   input logic [BLK_W:0]    cfg_tom,
   input logic              cfg_isa_hole_en,
   input logic              cfg_smr_en,
   input logic              cfg_smr_1m,
   input logic              cfg_gbuf_en,
   input logic              cfg_gbuf_1m,
   input logic [BLK_W-1:0]  cfg_greg_base,
   input logic              rsp_valid,
   input logic [3:0]        rsp_target,
   input logic              cfg_err
);
   logic low_req, greg_req;
   assign low_req  = (req_addr < ADDR_W'(32'h0010_0000));
   assign greg_req = !low_req && (req_addr[ADDR_W-1:BLK_LG] == cfg_greg_base);

   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> rsp_target == 4'b0000);
   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_target));
   assert_low_none_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && low_req |=> rsp_target == 4'b0000);
   assert_some_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !low_req |=> $countones(rsp_target) == 1);
   assert_greg_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && greg_req |=> rsp_target == 4'b0100);
endmodule

bind sys_addr_router sys_addr_router_chk #(.ADDR_W(ADDR_W), .BLK_LG(BLK_LG)) u_bound_chk (.*);

// File: tb/sys_addr_router_bench.sv
module sys_addr_router_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_smm = 1'b0;
   logic [13:0] cfg_tom = 14'd512;
   logic        cfg_isa_hole_en = 1'b0, cfg_smr_en = 1'b0, cfg_smr_1m = 1'b0;
   logic        cfg_gbuf_en = 1'b0, cfg_gbuf_1m = 1'b0;
   logic [12:0] cfg_greg_base = 13'h1000;
   logic        rsp_valid, cfg_err;
   logic [3:0]  rsp_target;

   int n_cmp = 0, n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   sys_addr_router u_sys_addr_router (.*);

   function automatic logic [3:0] exp_tgt(logic [31:0] a, logic smm);
      int b, tom, st, gt, gs;
      b   = int'(a >> 19);
      tom = int'(cfg_tom);
      if (a < 32'h0010_0000) return 4'b0000;
      if (b == int'(cfg_greg_base)) return 4'b0100;
      st = tom - (cfg_smr_1m ? 2 : 1);
      if (cfg_smr_en && b >= st && b < tom) return smm ? 4'b0001 : 4'b0010;
      gt = cfg_smr_en ? st : tom;
      gs = gt - (cfg_gbuf_1m ? 2 : 1);
      if (cfg_gbuf_en && b >= gs && b < gt) return 4'b1000;
      if (cfg_isa_hole_en && b >= 30 && b < 32) return 4'b0010;
      if (b < tom) return 4'b0001;
      return 4'b0010;
   endfunction

   function automatic logic exp_err();
      int g, gt, gs;
      g  = int'(cfg_greg_base);
      gt = int'(cfg_tom) - (cfg_smr_en ? (cfg_smr_1m ? 2 : 1) : 0);
      gs = gt - (cfg_gbuf_1m ? 2 : 1);
      if ((g >= 'h1FD8 && g < 'h1FDA) || (g >= 'h1FFC && g < 'h2000)) return 1'b1;
      if (cfg_gbuf_en && ((gs < 'h1FDA && 'h1FD8 < gt) || (gs < 'h2000 && 'h1FFC < gt)))
         return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive on falling edge, sample on next falling edge
   task automatic issue(string req, logic [31:0] a, logic smm);
      logic [3:0] e;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_smm = smm;
      e = exp_tgt(a, smm);
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, 32'(rsp_valid), 32'd1);
      check({req, " target"}, 32'(rsp_target), 32'(e));
   endtask

   task automatic chk_err(string req);
      @(negedge clk);
      @(negedge clk);
      check(req, 32'(cfg_err), 32'(exp_err()));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      check("R8 reset valid", 32'(rsp_valid), 32'd0);
      check("R8 reset target", 32'(rsp_target), 32'd0);
      rst_n = 1'b1;

      // directed corners
      issue("R1 low", 32'h000F_FFFF, 1'b0);
      issue("R2 dram", 32'h0010_0000, 1'b0);
      issue("R2 dram top-1", 32'h0FFF_FFFF, 1'b0);
      issue("R3 pci at tom", 32'h1000_0000, 1'b0);
      issue("R4 hole off", 32'h00F0_0000, 1'b0);
      cfg_isa_hole_en = 1'b1;
      issue("R4 hole on", 32'h00F0_0000, 1'b0);
      issue("R4 hole end", 32'h0100_0000, 1'b0);
      cfg_smr_en = 1'b1; cfg_smr_1m = 1'b1;
      issue("R5 smr smm", 32'h0FF0_0000, 1'b1);
      issue("R5 smr nonsmm", 32'h0FF0_0000, 1'b0);
      issue("R5 smr below", 32'h0FEF_FFFF, 1'b0);
      cfg_gbuf_en = 1'b1; cfg_gbuf_1m = 1'b0;
      issue("R6 gbuf under smr", 32'h0FE8_0000, 1'b0);
      issue("R6 gbuf below", 32'h0FE7_FFFF, 1'b0);
      cfg_smr_en = 1'b0;
      issue("R6 gbuf under tom", 32'h0FF8_0000, 1'b0);
      cfg_greg_base = 13'h01FF;
      issue("R7 greg over gbuf", 32'h0FF8_1234, 1'b0);
      cfg_greg_base = 13'h0040;
      issue("R7 greg in dram", 32'h0200_0010, 1'b0);
      @(negedge clk);
      check("R8 idle valid", 32'(rsp_valid), 32'd0);
      check("R8 idle target", 32'(rsp_target), 32'd0);
      chk_err("R9 clean");
      cfg_greg_base = 13'h1FD9; chk_err("R9 greg apic");
      cfg_greg_base = 13'h1FFC; chk_err("R9 greg bios");
      cfg_greg_base = 13'h1000; cfg_tom = 14'h1FDA; cfg_gbuf_1m = 1'b1;
      chk_err("R9 gbuf apic");
      cfg_tom = 14'h1FD8; chk_err("R9 gbuf just below");

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a;
         int k;
         if (i % 16 == 0) begin
            cfg_tom         = 14'(64 + ($urandom % 8129));
            cfg_isa_hole_en = 1'($urandom);
            cfg_smr_en      = 1'($urandom);
            cfg_smr_1m      = 1'($urandom);
            cfg_gbuf_en     = 1'($urandom);
            cfg_gbuf_1m     = 1'($urandom);
            cfg_greg_base   = ($urandom % 4 == 0) ? 13'(8'hD0 + $urandom % 48 + 13'h1F00)
                                                  : 13'($urandom);
            chk_err("R9 random");
         end
         k = int'($urandom % 6);
         case (k)
            0: a = $urandom;
            1: a = {cfg_tom[12:0] - 13'($urandom % 6), 19'($urandom)};
            2: a = 32'h00E0_0000 + ($urandom % 32'h0030_0000);
            3: a = {cfg_greg_base + 13'($urandom % 3) - 13'd1, 19'($urandom)};
            4: a = $urandom % 32'h0018_0000;
            default: a = {13'(cfg_tom) - 13'($urandom % 2), 19'($urandom)};
         endcase
         case (exp_tgt(a, 1'b0))
            4'b0000: issue("R1 rnd", a, 1'($urandom));
            4'b0100: issue("R7 rnd", a, 1'($urandom));
            4'b1000: issue("R6 rnd", a, 1'($urandom));
            default: issue("R2 R3 R4 R5 rnd", a, 1'($urandom));
         endcase
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule